// File: doc/BRIEF.md
# Burst Address Counter with Selectable Read Output Stage

This block produces the word address for one port of a synchronous memory and carries that port's read data out to the pins. On every rising clock edge three active-low controls decide what happens to the stored address. It can be cleared to zero or loaded from the external address bus. It can also step up by one or stay as it is. The controls follow a fixed priority: clear first, then load, then increment. The counter does not look at the chip enables, output enable or read/write, so a burst can go on stepping while the device is deselected.

Read data from the array arrives for the address the counter currently holds. The output stage passes that data through in the same cycle (flow-through), or registers it once so it appears one cycle later (pipelined). A static mode input selects the stage, and a build parameter can remove the register. The outputs drive only when every chip enable and the output enable select a read. At all other times a drive flag is low and the data lines read as zero. The memory array, the write path, a second port and any arbitration are outside this block.

Top module: `burst_port_addr`

## Requirements
- R1: At a rising edge with `cnt_clr_n` low, `addr` becomes 0, whatever `ld_n` and `inc_n` are.
- R2: At a rising edge with `cnt_clr_n` high and `ld_n` low, `addr` takes the value of `ext_addr` at that edge, whatever `inc_n` is.
- R3: At a rising edge with `cnt_clr_n` and `ld_n` high and `inc_n` low, `addr` becomes its previous value plus one; all ones wraps to 0.
- R4: At a rising edge with `cnt_clr_n`, `ld_n` and `inc_n` all high, `addr` keeps its value and `ext_addr` has no effect.
- R5: The counter actions of R1 to R4 happen the same way whatever `ce_lo_n`, `ce_hi`, `oe_n` and `rd_wr` are.
- R6: `dout_en` is 1 exactly when `ce_lo_n`=0, `ce_hi`=1, `oe_n`=0 and `rd_wr`=1 (1 means read); while `dout_en` is 0, `dout` is 0.
- R7: With `pipe_mode`=0 (flow-through), `dout` equals `rd_data` in the same cycle while driving, and `dout_valid` is 1.
- R8: With `pipe_mode`=1 (pipelined), `dout` while driving equals the `rd_data` present at the previous rising edge, and `dout_valid` is 1 from the first edge after reset ends.
- R9: At a rising edge with `rst_n` low, `addr`, the pipeline register and the pipelined `dout_valid` all clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pipe_mode | input | 1 | Static output mode: 1 pipelined, 0 flow-through |
| cnt_clr_n | input | 1 | Clears the counter, active low, highest priority |
| ld_n | input | 1 | Loads the external address, active low |
| inc_n | input | 1 | Advances the counter, active low |
| ext_addr | input | 14 | External address bus |
| ce_lo_n | input | 1 | Chip enable, active low |
| ce_hi | input | 1 | Chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| rd_wr | input | 1 | 1 read, 0 write |
| rd_data | input | 9 | Array read word for the current `addr` |
| addr | output | 14 | Internal address to the array |
| dout | output | 9 | Read data out, 0 when not driving |
| dout_en | output | 1 | Data output drive enable |
| dout_valid | output | 1 | Output stage holds valid data |

## Verification
The address changes one register after the controls are sampled, so it is due at the falling edge after the rising edge that saw them. In flow-through mode the data and the drive flag follow the current address and the enables with no register between, so they are checked at that same falling edge. In pipelined mode the data comes one edge later: the reference model keeps the array word of the address held before each edge and compares it one cycle on. The bench drives at falling edges, updates its model just after each rising edge and compares every output at the next falling edge.

// File: rtl/burst_pkg.sv
// Package: shared types for the burst address port.
// Assumes: nothing beyond IEEE 1800-2017.
package burst_pkg;

    // Counter action picked for one clock edge, after priority is applied.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_INCR  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } cnt_act_e;

endpackage

// File: rtl/burst_ctrl_decode.sv
// Module: burst_ctrl_decode
// Turns the three active-low counter controls into one action.
// Priority: clear over load, load over increment, increment over hold.
// Assumes: the controls are stable around the rising clock edge.
module burst_ctrl_decode
    import burst_pkg::*;
(
    input  logic     cnt_clr_n,
    input  logic     ld_n,
    input  logic     inc_n,
    output cnt_act_e act
);

    // Priority encoder of the counter controls.
    always_comb begin
        if (!cnt_clr_n)  act = ACT_CLEAR;
        else if (!ld_n)  act = ACT_LOAD;
        else if (!inc_n) act = ACT_INCR;
        else             act = ACT_HOLD;
    end

endmodule

// File: rtl/burst_addr_reg.sv
// Module: burst_addr_reg
// Holds the internal address and applies the decoded action each edge.
// Increment wraps from all ones to zero through the natural width.
// Assumes: synchronous active-low reset, rising-edge clock.
module burst_addr_reg
    import burst_pkg::*;
#(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cnt_act_e      act,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_nxt;

    // Next-address selection from the action.
    always_comb begin
        unique case (act)
            ACT_CLEAR: addr_nxt = '0;
            ACT_LOAD:  addr_nxt = ext_addr;
            ACT_INCR:  addr_nxt = addr_q + ONE;
            default:   addr_nxt = addr_q;
        endcase
    end

    // Address register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_nxt;
    end

    assign addr = addr_q;

endmodule

// File: rtl/burst_read_path.sv
// Module: burst_read_path
// Read data output stage: flow-through, or one register stage when
// pipe_mode is 1. PIPE_EN=0 builds the flow-through path only.
// Output lines read zero while drive is low.
// Assumes: pipe_mode is static configuration; rd_data matches the
// address currently held by the counter.
module burst_read_path #(
    parameter int DW      = 9,
    parameter bit PIPE_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_mode,
    input  logic          drive,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] dout,
    output logic          dout_valid
);

    logic [DW-1:0] sel_data;
    logic          sel_valid;

    generate
        if (PIPE_EN) begin : g_pipe
            logic [DW-1:0] pipe_q;
            logic          vld_q;

            // Pipeline register and its valid flag.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe_q <= '0;
                    vld_q  <= 1'b0;
                end else begin
                    pipe_q <= rd_data;
                    vld_q  <= 1'b1;
                end
            end

            // Mode selection between registered and direct data.
            always_comb begin
                sel_data  = pipe_mode ? pipe_q : rd_data;
                sel_valid = pipe_mode ? vld_q  : 1'b1;
            end
        end else begin : g_flow
            // Direct path only.
            always_comb begin
                sel_data  = rd_data;
                sel_valid = 1'b1;
            end
        end
    endgenerate

    // Output gating by the drive enable.
    always_comb begin
        dout       = drive ? sel_data : '0;
        dout_valid = sel_valid;
    end

endmodule

// File: rtl/burst_port_addr.sv
// Module: burst_port_addr (top)
// One memory port's address counter and read output stage. Counter
// controls ignore the chip enables; only the data drive uses them.
// Assumes: rd_data comes from an array addressed by addr, combinationally.
module burst_port_addr #(
    parameter int AW      = 14,
    parameter int DW      = 9,
    parameter bit PIPE_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_mode,
    input  logic          cnt_clr_n,
    input  logic          ld_n,
    input  logic          inc_n,
    input  logic [AW-1:0] ext_addr,
    input  logic          ce_lo_n,
    input  logic          ce_hi,
    input  logic          oe_n,
    input  logic          rd_wr,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          dout_valid
);

    import burst_pkg::*;

    cnt_act_e act;
    logic     drive;

    // Read drive qualification from enables and direction.
    always_comb drive = !ce_lo_n && ce_hi && !oe_n && rd_wr;

    burst_ctrl_decode u_dec (
        .cnt_clr_n (cnt_clr_n),
        .ld_n      (ld_n),
        .inc_n     (inc_n),
        .act       (act)
    );

    burst_addr_reg #(.AW(AW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .ext_addr (ext_addr),
        .addr     (addr)
    );

    burst_read_path #(.DW(DW), .PIPE_EN(PIPE_EN)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .pipe_mode  (pipe_mode),
        .drive      (drive),
        .rd_data    (rd_data),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    assign dout_en = drive;

endmodule

// File: rtl/burst_port_addr_chk.sv
// Module: burst_port_addr_chk
// Port-level properties for burst_port_addr, attached by bind.
// Assumes: pipe_mode only changes while rst_n is low.
module burst_port_addr_chk #(
    parameter int AW = 14,
    parameter int DW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pipe_mode,
    input logic          cnt_clr_n,
    input logic          ld_n,
    input logic          inc_n,
    input logic [AW-1:0] ext_addr,
    input logic          ce_lo_n,
    input logic          ce_hi,
    input logic          oe_n,
    input logic          rd_wr,
    input logic [DW-1:0] rd_data,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] dout,
    input logic          dout_en,
    input logic          dout_valid
);

    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr_n |=> addr == '0);

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr_n && !ld_n) |=> addr == $past(ext_addr));

    assert_incr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr_n && ld_n && !inc_n) |=> addr == AW'($past(addr) + 1'b1));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr_n && ld_n && inc_n) |=> $stable(addr));

    assert_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_lo_n || !ce_hi || oe_n || !rd_wr) |-> !dout_en);

    assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> dout == '0);

    assert_flow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && dout_en) |-> (dout == rd_data && dout_valid));

    assert_pipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && dout_valid && dout_en) |-> dout == $past(rd_data));

endmodule

bind burst_port_addr burst_port_addr_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .cnt_clr_n(cnt_clr_n),
    .ld_n(ld_n), .inc_n(inc_n), .ext_addr(ext_addr), .ce_lo_n(ce_lo_n),
    .ce_hi(ce_hi), .oe_n(oe_n), .rd_wr(rd_wr), .rd_data(rd_data),
    .addr(addr), .dout(dout), .dout_en(dout_en), .dout_valid(dout_valid)
);

// File: tb/tb_burst_port_addr.sv
module tb_burst_port_addr;

    localparam int AW = 14;
    localparam int DW = 9;

    logic          clk = 1'b0;
    logic          rst_n, pipe_mode, cnt_clr_n, ld_n, inc_n;
    logic [AW-1:0] ext_addr;
    logic          ce_lo_n, ce_hi, oe_n, rd_wr;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] addr;
    logic [DW-1:0] dout;
    logic          dout_en, dout_valid;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // Reference state
    int unsigned   m_addr = 0;
    int unsigned   m_pipe = 0;
    bit            m_vld  = 0;

    always #10ns clk = ~clk;

    // Behavioural array contents
    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        int unsigned v;
        v = (int'(a) * 37 + 11) ^ (int'(a) >> 4);
        return DW'(v);
    endfunction

    assign rd_data = mem_word(addr);

    burst_port_addr dut (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .cnt_clr_n(cnt_clr_n),
        .ld_n(ld_n), .inc_n(inc_n), .ext_addr(ext_addr), .ce_lo_n(ce_lo_n),
        .ce_hi(ce_hi), .oe_n(oe_n), .rd_wr(rd_wr), .rd_data(rd_data),
        .addr(addr), .dout(dout), .dout_en(dout_en), .dout_valid(dout_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at falling edge, model after rising edge, compare at next falling edge
    task automatic step(input bit r, input bit clr, input bit ld, input bit inc,
                        input int ea, input bit cl, input bit ch, input bit oe, input bit rw);
        string atag;
        bit    en;
        int    exp_d;
        rst_n = r; cnt_clr_n = clr; ld_n = ld; inc_n = inc; ext_addr = AW'(ea);
        ce_lo_n = cl; ce_hi = ch; oe_n = oe; rd_wr = rw;
        @(posedge clk);
        #1ns;
        if (!r) begin
            m_addr = 0; m_pipe = 0; m_vld = 0; atag = "R9";
        end else begin
            m_pipe = int'(mem_word(AW'(m_addr)));
            m_vld  = 1;
            if (!clr)      begin m_addr = 0;                          atag = "R1"; end
            else if (!ld)  begin m_addr = ea % (1 << AW);             atag = "R2"; end
            else if (!inc) begin m_addr = (m_addr + 1) % (1 << AW);   atag = "R3"; end
            else           atag = "R4";
            if (cl || !ch) atag = {atag, "/R5"};
        end
        @(negedge clk);
        en = !cl && ch && !oe && rw;
        chk({"addr ", atag}, int'(addr), int'(m_addr));
        chk("dout_en R6", int'(dout_en), int'(en));
        if (pipe_mode) begin
            exp_d = en ? int'(m_pipe) : 0;
            chk("dout R8", int'(dout), exp_d);
            chk("dout_valid R8/R9", int'(dout_valid), int'(m_vld));
        end else begin
            exp_d = en ? int'(mem_word(AW'(m_addr))) : 0;
            chk(en ? "dout R7" : "dout R6", int'(dout), exp_d);
            chk("dout_valid R7", int'(dout_valid), 1);
        end
    endtask

    task automatic run_phase(input bit mode);
        pipe_mode = mode;
        step(0, 1, 1, 1, 0, 0, 1, 0, 1);
        step(0, 0, 0, 0, 5, 0, 1, 0, 1);
        // R2: load near the top, R3: count through the wrap
        step(1, 1, 0, 1, 14'h3FFE, 0, 1, 0, 1);
        step(1, 1, 1, 0, 14'h0123, 0, 1, 0, 1);
        step(1, 1, 1, 0, 14'h0456, 0, 1, 0, 1);
        step(1, 1, 1, 0, 14'h0789, 0, 1, 0, 1);
        // R4: hold while external bus moves
        step(1, 1, 1, 1, 14'h2AAA, 0, 1, 0, 1);
        step(1, 1, 1, 1, 14'h1555, 0, 1, 0, 1);
        // R1 with load and count asserted; R2 with count asserted
        step(1, 0, 0, 0, 14'h1234, 0, 1, 0, 1);
        step(1, 1, 0, 0, 14'h2345, 0, 1, 0, 1);
        // R5: counting and loading while deselected
        step(1, 1, 1, 0, 0, 1, 1, 0, 1);
        step(1, 1, 1, 0, 0, 0, 0, 0, 1);
        step(1, 1, 0, 1, 14'h0F0F, 1, 0, 1, 0);
        // R6: each enable alone off
        step(1, 1, 1, 0, 0, 0, 1, 1, 1);
        step(1, 1, 1, 0, 0, 0, 1, 0, 0);
        // All eight control combinations
        for (int i = 0; i < 8; i++)
            step(1, i[2], i[1], i[0], i * 14'h0811, 0, 1, 0, 1);
        // Mixed stimulus
        for (int i = 0; i < 300; i++) begin
            int unsigned r;
            r = $urandom;
            step(1, (r % 13) != 0, (r[7:4] != 0), r[8], int'(r[31:18]),
                 r[9] & r[10], r[11] | r[12], r[13] & r[14], r[15] | r[16]);
        end
    endtask

    initial begin
        void'($urandom(32'h1F2E3D));
        rst_n = 0; pipe_mode = 0; cnt_clr_n = 1; ld_n = 1; inc_n = 1; ext_addr = '0;
        ce_lo_n = 1; ce_hi = 0; oe_n = 1; rd_wr = 1;
        @(negedge clk);
        run_phase(0);
        run_phase(1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20ns * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule